// File: doc/BRIEF.md
# Guard-Bit Rounding Unit for Unpacked Floating-Point Values

This block takes a floating-point value that is already unpacked into a sign, a class code, a signed unbiased exponent and a normalised fraction. It rounds the fraction to its kept precision and reports what happened through a small flag vector. The fraction carries an implicit leading one at bit `FRAC_W-2`. The bit above it is reserved for the carry of a rounding increment. The lowest `GUARD_W` bits are guard bits that the rounding discards.

When the exponent is below the smallest normal exponent, the block does not shift the fraction. It widens the guard field by the size of the deficit instead, so one increment path produces both normal and subnormal results. Special classes pass straight through, except that a signalling NaN is quietened. Packing into an interchange bit format is left to a later stage. Overflow and total loss of value give fixed stub results: infinity and signed zero.

The rounding logic is combinational. An optional output register stage (`OUT_REG`) carries the result and a valid bit, one cycle after the input valid.

Top module: `fpr_unit`

## Requirements
- R1: For a number in the normal exponent range whose guard bits (fraction bits `GUARD_W-1..0`) are all zero, the output sign, exponent and fraction equal the input and the flag vector is zero.
- R2: With `round_mode` 0 (nearest), the value is incremented at the lowest kept bit when the discarded part is above half of that bit. On an exact half, it is incremented only if the lowest kept bit is 1, which gives ties to even.
- R3: `round_mode` 1 (toward +inf) increments only positive inexact values. Mode 2 (toward -inf) increments only negative inexact values. Mode 3 (toward zero) never increments.
- R4: The flag vector `out_flags` has bit 0 inexact, bit 1 rounded, bit 2 denormal, bit 3 underflow, bit 4 overflow and bit 5 invalid. Nonzero discarded bits set inexact. An increment also sets rounded, and rounded never appears without inexact.
- R5: After the discarded bits are cleared and the increment is applied, a carry into bit `FRAC_W-1` shifts the fraction right by one and adds one to the exponent.
- R6: Class codes are 0 number, 1 denormal, 2 zero, 3 infinity, 4 quiet NaN and 5 signalling NaN. Classes 2, 3 and 4 pass through unchanged with no flags. Class 5 leaves as class 4 with only the invalid flag set.
- R7: For an exponent below `EMIN`, the guard count becomes `GUARD_W + (EMIN - exp)`. If that count exceeds `FRAC_W-1`, or if `flush_denorm` is 1, the result is a zero of the input sign (class 2, exponent 0, fraction 0) with the underflow and inexact flags set.
- R8: If a widened-guard rounding leaves the exponent still below `EMIN`, the result has class 1 and the denormal flag set. Underflow is added only when the result is inexact. A carry that lifts the exponent to `EMIN` gives class 0 with no denormal or underflow flag.
- R9: An exponent above `EMAX`, either on input or after the rounding carry, gives class 3 with exponent 0 and fraction 0. The overflow and inexact flags are set, on top of any rounding flags.
- R10: If the rounded fraction is zero, the result is a signed zero with the underflow and inexact flags added.
- R11: With `OUT_REG`=1, `out_valid` follows `in_valid` one clock later and the result belongs to the input of that earlier cycle. A synchronous reset clears `out_valid` and all output fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input value present |
| in_sign | input | 1 | Input sign, 1 = negative |
| in_class | input | 3 | Input class code |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_frac | input | FRAC_W | Normalised fraction with guard bits |
| round_mode | input | 2 | Rounding direction |
| flush_denorm | input | 1 | Flush sub-minimum values to zero |
| out_valid | output | 1 | Result present |
| out_sign | output | 1 | Result sign |
| out_class | output | 3 | Result class code |
| out_exp | output | EXP_W | Result exponent |
| out_frac | output | FRAC_W | Rounded fraction |
| out_flags | output | 6 | Status flags |

## Verification
The bench builds the block with a 32-bit fraction, 8 guard bits, a 12-bit exponent and an exponent range of -30 to +30, with the output register enabled. The narrow range puts overflow before and after rounding within a few steps of random exponents. It also lets the widened guard field reach its upper limit of 31 bits, so the exact half-ulp-of-everything case becomes reachable: there the implicit one is itself the half bit and the rounding either vanishes to zero or carries back to a denormal. Random exponents run past both ends, which covers the direct-underflow path as well.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  typedef enum logic [2:0] {
    FC_NUM  = 3'd0,
    FC_SUB  = 3'd1,
    FC_ZERO = 3'd2,
    FC_INF  = 3'd3,
    FC_QNAN = 3'd4,
    FC_SNAN = 3'd5
  } fclass_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_POS  = 2'd1,
    RM_NEG  = 2'd2,
    RM_ZERO = 2'd3
  } rmode_e;

  typedef enum logic [2:0] {
    P_KEEP     = 3'd0,
    P_QUIET    = 3'd1,
    P_OVF      = 3'd2,
    P_UNF      = 3'd3,
    P_RND_NORM = 3'd4,
    P_RND_SUB  = 3'd5
  } path_e;

  localparam int FLG_W  = 6;
  localparam int FL_INX = 0;
  localparam int FL_RND = 1;
  localparam int FL_DEN = 2;
  localparam int FL_UNF = 3;
  localparam int FL_OVF = 4;
  localparam int FL_INV = 5;

endpackage

// File: rtl/fpr_path_sel.sv
module fpr_path_sel
  import fpr_pkg::*;
#(
  parameter int FRAC_W  = 64,
  parameter int GUARD_W = 8,
  parameter int EXP_W   = 16,
  parameter int EMIN    = -126,
  parameter int EMAX    = 127,
  parameter int CNT_W   = $clog2(FRAC_W)
) (
  input  logic [2:0]       cls,
  input  logic [EXP_W-1:0] exp_in,
  input  logic             ftz,
  output path_e            path,
  output logic [CNT_W-1:0] gcnt
);
  localparam int WIDE = EXP_W + 2;
  localparam logic signed [WIDE-1:0] EMIN_W  = WIDE'(EMIN);
  localparam logic signed [WIDE-1:0] EMAX_W  = WIDE'(EMAX);
  localparam logic signed [WIDE-1:0] GRD_W   = WIDE'(GUARD_W);
  localparam logic signed [WIDE-1:0] LIMIT_W = WIDE'(FRAC_W - 1);

  logic signed [WIDE-1:0] exp_w, deficit, total;

  always_comb begin
    exp_w   = {{2{exp_in[EXP_W-1]}}, exp_in};
    deficit = EMIN_W - exp_w;
    total   = deficit + GRD_W;
  end

  always_comb begin
    path = P_KEEP;
    gcnt = CNT_W'(GUARD_W);
    case (fclass_e'(cls))
      FC_NUM, FC_SUB: begin
        if (exp_w > EMAX_W) begin
          path = P_OVF;
        end else if (exp_w < EMIN_W) begin
          if (!ftz && (total <= LIMIT_W)) begin
            path = P_RND_SUB;
            gcnt = total[CNT_W-1:0];
          end else begin
            path = P_UNF;
          end
        end else begin
          path = P_RND_NORM;
        end
      end
      FC_SNAN: path = P_QUIET;
      default: path = P_KEEP;
    endcase
  end
endmodule

// File: rtl/fpr_round_core.sv
module fpr_round_core
  import fpr_pkg::*;
#(
  parameter int FRAC_W = 64,
  parameter int EXP_W  = 16,
  parameter int CNT_W  = $clog2(FRAC_W)
) (
  input  logic              sign,
  input  logic [1:0]        mode,
  input  logic [CNT_W-1:0]  gcnt,
  input  logic [FRAC_W-1:0] frac_in,
  input  logic [EXP_W-1:0]  exp_in,
  output logic [FRAC_W-1:0] frac_out,
  output logic [EXP_W-1:0]  exp_out,
  output logic              inexact,
  output logic              incr
);
  logic [FRAC_W-1:0] lsb_bit, mask, half_bit, rem, cleared, sum;
  logic              half_set, below_half, kept_odd;

  always_comb begin
    lsb_bit    = FRAC_W'(1) << gcnt;
    mask       = lsb_bit - FRAC_W'(1);
    half_bit   = lsb_bit >> 1;
    rem        = frac_in & mask;
    inexact    = |rem;
    half_set   = |(rem & half_bit);
    below_half = |(rem & (half_bit - FRAC_W'(1)));
    kept_odd   = |(frac_in & lsb_bit);
    case (rmode_e'(mode))
      RM_NEAR: incr = half_set && (kept_odd || below_half);
      RM_POS:  incr = inexact && !sign;
      RM_NEG:  incr = inexact && sign;
      default: incr = 1'b0;
    endcase
    cleared = frac_in & ~mask;
    sum     = cleared + (incr ? lsb_bit : '0);
    if (sum[FRAC_W-1]) begin
      frac_out = sum >> 1;
      exp_out  = exp_in + EXP_W'(1);
    end else begin
      frac_out = sum;
      exp_out  = exp_in;
    end
  end
endmodule

// File: rtl/fpr_unit.sv
module fpr_unit
  import fpr_pkg::*;
#(
  parameter int FRAC_W  = 64,
  parameter int GUARD_W = 8,
  parameter int EXP_W   = 16,
  parameter int EMIN    = -126,
  parameter int EMAX    = 127,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sign,
  input  logic [2:0]        in_class,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [FRAC_W-1:0] in_frac,
  input  logic [1:0]        round_mode,
  input  logic              flush_denorm,
  output logic              out_valid,
  output logic              out_sign,
  output logic [2:0]        out_class,
  output logic [EXP_W-1:0]  out_exp,
  output logic [FRAC_W-1:0] out_frac,
  output logic [FLG_W-1:0]  out_flags
);
  localparam int CNT_W = $clog2(FRAC_W);
  localparam int IMPL  = FRAC_W - 2;
  localparam logic signed [EXP_W-1:0] EMIN_E = EXP_W'(EMIN);
  localparam logic signed [EXP_W-1:0] EMAX_E = EXP_W'(EMAX);

  path_e             path;
  logic [CNT_W-1:0]  gcnt;
  logic [FRAC_W-1:0] c_frac;
  logic [EXP_W-1:0]  c_exp;
  logic              c_inexact, c_incr;

  fpr_path_sel #(
    .FRAC_W(FRAC_W), .GUARD_W(GUARD_W), .EXP_W(EXP_W),
    .EMIN(EMIN), .EMAX(EMAX), .CNT_W(CNT_W)
  ) u_sel (
    .cls(in_class), .exp_in(in_exp), .ftz(flush_denorm),
    .path(path), .gcnt(gcnt)
  );

  fpr_round_core #(
    .FRAC_W(FRAC_W), .EXP_W(EXP_W), .CNT_W(CNT_W)
  ) u_core (
    .sign(in_sign), .mode(round_mode), .gcnt(gcnt),
    .frac_in(in_frac), .exp_in(in_exp),
    .frac_out(c_frac), .exp_out(c_exp),
    .inexact(c_inexact), .incr(c_incr)
  );

  logic              r_sign;
  logic [2:0]        r_class;
  logic [EXP_W-1:0]  r_exp;
  logic [FRAC_W-1:0] r_frac;
  logic [FLG_W-1:0]  r_flags;

  always_comb begin
    r_sign  = in_sign;
    r_class = in_class;
    r_exp   = in_exp;
    r_frac  = in_frac;
    r_flags = '0;
    case (path)
      P_QUIET: begin
        r_class = FC_QNAN;
        r_flags[FL_INV] = 1'b1;
      end
      P_OVF: begin
        r_class = FC_INF;
        r_exp   = '0;
        r_frac  = '0;
        r_flags[FL_OVF] = 1'b1;
        r_flags[FL_INX] = 1'b1;
      end
      P_UNF: begin
        r_class = FC_ZERO;
        r_exp   = '0;
        r_frac  = '0;
        r_flags[FL_UNF] = 1'b1;
        r_flags[FL_INX] = 1'b1;
      end
      P_RND_NORM, P_RND_SUB: begin
        r_class = FC_NUM;
        r_exp   = c_exp;
        r_frac  = c_frac;
        r_flags[FL_INX] = c_inexact;
        r_flags[FL_RND] = c_incr;
        if (c_frac == '0) begin
          r_class = FC_ZERO;
          r_exp   = '0;
          r_flags[FL_UNF] = 1'b1;
          r_flags[FL_INX] = 1'b1;
        end else if ((path == P_RND_SUB) && ($signed(c_exp) < EMIN_E)) begin
          r_class = FC_SUB;
          r_flags[FL_DEN] = 1'b1;
          r_flags[FL_UNF] = c_inexact;
        end else if ($signed(c_exp) > EMAX_E) begin
          r_class = FC_INF;
          r_exp   = '0;
          r_frac  = '0;
          r_flags[FL_OVF] = 1'b1;
          r_flags[FL_INX] = 1'b1;
        end
      end
      default: ;
    endcase
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          out_sign  <= 1'b0;
          out_class <= '0;
          out_exp   <= '0;
          out_frac  <= '0;
          out_flags <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            out_sign  <= r_sign;
            out_class <= r_class;
            out_exp   <= r_exp;
            out_frac  <= r_frac;
            out_flags <= r_flags;
          end
        end
      end

      AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)))
        else $error("valid pipe"); // R11
    end else begin : g_comb
      always_comb begin
        out_valid = in_valid;
        out_sign  = r_sign;
        out_class = r_class;
        out_exp   = r_exp;
        out_frac  = r_frac;
        out_flags = r_flags;
      end
    end
  endgenerate

  AST_ROUNDED_NEEDS_INEXACT: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_flags[FL_RND] |-> out_flags[FL_INX])
    else $error("rounded without inexact"); // R4

  AST_FRAC_NORMALISED: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_class == FC_NUM || out_class == FC_SUB) |->
      (out_frac[IMPL] && !out_frac[FRAC_W-1]))
    else $error("fraction out of range"); // R5

  AST_DENORM_FLAG_CLASS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_flags[FL_DEN] == (out_class == FC_SUB)))
    else $error("denormal flag mismatch"); // R8

  AST_INVALID_GIVES_QNAN: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_flags[FL_INV] |-> (out_class == FC_QNAN))
    else $error("invalid without qnan"); // R6

  AST_UNF_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_flags[FL_UNF] && !out_flags[FL_DEN] |->
      (out_class == FC_ZERO && out_frac == '0))
    else $error("underflow result not zero"); // R10

  AST_OVF_IS_INF: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_flags[FL_OVF] |-> (out_class == FC_INF && out_flags[FL_INX]))
    else $error("overflow result not infinity"); // R9
endmodule

// File: tb/tb_fpr_unit.sv
module tb_fpr_unit;
  localparam int FRAC_W  = 32;
  localparam int GUARD_W = 8;
  localparam int EXP_W   = 12;
  localparam int EMIN    = -30;
  localparam int EMAX    = 30;
  localparam int IMPL    = FRAC_W - 2;
  localparam longint ONE = longint'(1) << IMPL;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_sign = 1'b0;
  logic [2:0]        in_class = '0;
  logic [EXP_W-1:0]  in_exp = '0;
  logic [FRAC_W-1:0] in_frac = '0;
  logic [1:0]        round_mode = '0;
  logic              flush_denorm = 1'b0;
  logic              out_valid, out_sign;
  logic [2:0]        out_class;
  logic [EXP_W-1:0]  out_exp;
  logic [FRAC_W-1:0] out_frac;
  logic [5:0]        out_flags;

  always #4 clk = ~clk;

  fpr_unit #(
    .FRAC_W(FRAC_W), .GUARD_W(GUARD_W), .EXP_W(EXP_W),
    .EMIN(EMIN), .EMAX(EMAX), .OUT_REG(1'b1)
  ) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
    .in_class(in_class), .in_exp(in_exp), .in_frac(in_frac),
    .round_mode(round_mode), .flush_denorm(flush_denorm),
    .out_valid(out_valid), .out_sign(out_sign), .out_class(out_class),
    .out_exp(out_exp), .out_frac(out_frac), .out_flags(out_flags)
  );

  int     n_vec = 0;
  int     n_bad = 0;
  bit     e_valid, e_sign;
  int     e_class, e_exp, e_flags;
  longint e_frac;
  string  e_tag;

  task automatic model(input bit s, input int cls, input int ex, input longint fr,
                       input int md, input bit ftz);
    int g; longint unit, rem, kept; bit up, sub;
    e_sign = s; e_class = cls; e_exp = ex; e_frac = fr; e_flags = 0; e_tag = "R6";
    if (cls == 5) begin e_class = 4; e_flags = 32; return; end
    if (cls != 0 && cls != 1) return;
    if (ex > EMAX) begin
      e_class = 3; e_exp = 0; e_frac = 0; e_flags = 17; e_tag = "R9"; return;
    end
    sub = (ex < EMIN);
    g = GUARD_W;
    if (sub) begin
      g = GUARD_W + EMIN - ex;
      if (ftz || g > IMPL + 1) begin
        e_class = 2; e_exp = 0; e_frac = 0; e_flags = 9; e_tag = "R7"; return;
      end
    end
    unit = longint'(1) << g;
    rem  = fr % unit;
    kept = fr / unit;
    up   = 1'b0;
    e_tag = (rem == 0) ? "R1" : ((md == 0) ? "R2" : "R3");
    if (rem != 0) begin
      e_flags = 1;
      case (md)
        0: up = (rem * 2 > unit) || (rem * 2 == unit && kept % 2 == 1);
        1: up = !s;
        2: up = s;
        default: up = 1'b0;
      endcase
    end
    fr = kept * unit;
    if (up) begin
      e_flags = e_flags | 2;
      fr = fr + unit;
      if (fr >= (longint'(1) << (IMPL + 1))) begin
        fr = fr / 2; ex = ex + 1; e_tag = "R5";
      end
    end
    e_class = 0; e_exp = ex; e_frac = fr;
    if (fr == 0) begin
      e_class = 2; e_exp = 0; e_flags = e_flags | 9; e_tag = "R10";
    end else if (sub && ex < EMIN) begin
      e_class = 1; e_flags = e_flags | 4; e_tag = "R8";
      if (e_flags % 2 == 1) e_flags = e_flags | 8;
    end else if (ex > EMAX) begin
      e_class = 3; e_exp = 0; e_frac = 0; e_flags = e_flags | 17; e_tag = "R9";
    end
  endtask

  task automatic step(input bit v, input bit s, input int cls, input int ex,
                      input longint fr, input int md, input bit ftz, input string tag);
    int a_exp;
    @(negedge clk);
    in_valid = v; in_sign = s; in_class = cls[2:0]; in_exp = ex[EXP_W-1:0];
    in_frac = fr[FRAC_W-1:0]; round_mode = md[1:0]; flush_denorm = ftz;
    e_valid = v;
    if (v) model(s, cls, ex, fr, md, ftz);
    if (tag != "") e_tag = tag;
    @(posedge clk);
    #1;
    n_vec++;
    if (out_valid !== e_valid) begin
      n_bad++;
      $display("FAIL R11 out_valid: actual=%0b expected=%0b", out_valid, e_valid);
    end else if (v) begin
      a_exp = int'($signed(out_exp));
      if (out_sign !== e_sign || int'(out_class) != e_class || a_exp != e_exp ||
          longint'(out_frac) != e_frac || int'(out_flags) != e_flags) begin
        n_bad++;
        $display("FAIL %s: actual s=%0b c=%0d e=%0d f=%h fl=%b expected s=%0b c=%0d e=%0d f=%h fl=%b",
                 e_tag, out_sign, out_class, a_exp, out_frac, out_flags,
                 e_sign, e_class, e_exp, e_frac[FRAC_W-1:0], e_flags[5:0]);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n_vec++;
    if (out_valid !== 1'b0 || out_flags !== '0 || out_frac !== '0) begin
      n_bad++;
      $display("FAIL R11 reset: actual v=%0b fl=%b expected v=0 fl=0", out_valid, out_flags);
    end
    // R1 exact value
    step(1, 0, 0, 3, ONE | 64'h1200, 0, 0, "R1");
    // R2 ties and above-half
    step(1, 0, 0, 2, ONE | 64'h0080, 0, 0, "R2");
    step(1, 1, 0, 2, ONE | 64'h0180, 0, 0, "R2");
    step(1, 0, 0, 2, ONE | 64'h0081, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, "R11");
    // R3 directed modes, R4 flags
    step(1, 0, 0, 1, ONE | 64'h0001, 1, 0, "R3");
    step(1, 1, 0, 1, ONE | 64'h0001, 1, 0, "R3");
    step(1, 1, 0, 1, ONE | 64'h00FF, 2, 0, "R3");
    step(1, 0, 0, 1, ONE | 64'h00FF, 2, 0, "R3");
    step(1, 0, 0, 1, ONE | 64'h00FF, 3, 0, "R4");
    // R5 carry
    step(1, 0, 0, 5, 64'h7FFF_FFFF, 0, 0, "R5");
    // R9 overflow before and after rounding
    step(1, 1, 0, 31, ONE, 0, 0, "R9");
    step(1, 0, 0, 30, 64'h7FFF_FFFF, 0, 0, "R9");
    // R8 denormal cases
    step(1, 0, 0, -31, ONE | 64'h0100, 0, 0, "R8");
    step(1, 0, 0, -31, ONE | 64'h0200, 0, 0, "R8");
    step(1, 0, 0, -31, 64'h7FFF_FFFF, 0, 0, "R8");
    // R10 vanishing and revived values at the widest guard field
    step(1, 1, 0, -53, ONE, 0, 0, "R10");
    step(1, 0, 0, -53, ONE, 1, 0, "R10");
    // R7 direct underflow and flush
    step(1, 1, 0, -54, ONE | 64'h5555, 1, 0, "R7");
    step(1, 0, 1, -31, ONE | 64'h0200, 0, 1, "R7");
    // R6 special classes
    step(1, 1, 2, 7, 64'h1234, 1, 0, "R6");
    step(1, 0, 3, -5, 64'h0, 2, 0, "R6");
    step(1, 1, 4, 9, ONE | 64'h33, 0, 0, "R6");
    step(1, 0, 5, 9, ONE | 64'h44, 0, 0, "R6");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int cls;
      cls = ($urandom_range(0, 9) < 8) ? int'($urandom_range(0, 1)) : int'($urandom_range(2, 5));
      step($urandom_range(0, 5) != 0, $urandom_range(0, 1),
           cls,
           int'($urandom_range(0, (EMAX + 2) - (EMIN - 26))) + EMIN - 26,
           ONE | (longint'($urandom) & (ONE - 1)),
           int'($urandom_range(0, 3)), $urandom_range(0, 7) == 0, "");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R11");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule